// File: doc/BRIEF.md
# Age-Ordered Issue Selector

This block sits beside an instruction window of `W` entries and decides, every clock, which waiting entries leave for execution. For each entry it receives a ready flag, a wrap-around sequence number that orders entries by age, and a small unit-class code naming the kind of execution unit the entry needs. Each of the `N` issue slots also carries the class of the unit it feeds. The block returns one grant vector per slot, at most one bit set in each, registered so the result appears one cycle after the inputs it was computed from.

Three selection schemes are chosen at run time. In the shared-window scheme every slot may search the whole window, slots are served in ascending order, and an entry taken by a lower slot is hidden from the higher ones. In the partitioned scheme the window is cut into `N` equal contiguous banks, slot `s` searching only bank `s`. In the queue-head scheme slot `s` looks at a single entry of bank `s`, pointed to by a per-slot head index, and never searches. Window storage, wakeup and the units themselves lie outside the block.

Top module: `age_issue_select`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every bit of `grant_o` and `grant_vld_o` is 0.
- R2: Grants are registered: the grant seen after rising edge k is computed from the inputs sampled at edge k and holds unchanged until edge k+1.
- R3: An entry is never granted to slot s unless its class field `cls_i[e*CLS_W +: CLS_W]` equals that slot's `slot_cls_i[s*CLS_W +: CLS_W]`; a ready entry of another class gets no grant from that slot.
- R4: Only entries whose `ready_i` bit is 1 are granted.
- R5: In shared-window mode (`mode_i` = 0) slot 0 grants the oldest ready, class-matching entry whenever one exists; among entries of equal age the lowest index wins.
- R6: Entry a is older than entry b when `(age_a - age_b) mod 2^AGE_W` has its top bit set, so an age of 15 is older than an age of 1 when `AGE_W` is 4.
- R7: In shared-window mode slot s > 0 grants the oldest eligible entry not already granted by slots below s; no entry is granted to two slots in the same cycle.
- R8: In partitioned mode (`mode_i` = 1) slot s grants only within entries `s*B` to `s*B+B-1`, with `B = W/N`, and picks the oldest eligible entry there, ties to the lowest index.
- R9: In queue-head mode (`mode_i` = 2) slot s grants entry `s*B + head_i[s*HEAD_W +: HEAD_W]` if it is ready and matches, and grants nothing otherwise, even when other entries of its bank are eligible.
- R10: Each slot's grant vector has at most one bit set and `grant_vld_o[s]` is 1 exactly when it has one.
- R11: `mode_i` = 3 selects exactly as shared-window mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 shared window, 1 partitioned, 2 queue head, 3 as 0 |
| ready_i | input | W | Per-entry ready flag |
| age_i | input | W*AGE_W | Per-entry sequence number, entry e at bits e*AGE_W |
| cls_i | input | W*CLS_W | Per-entry unit class, entry e at bits e*CLS_W |
| slot_cls_i | input | N*CLS_W | Unit class served by each slot |
| head_i | input | N*HEAD_W | Head index inside each bank, used in queue-head mode |
| grant_o | output | N*W | Grant vector of slot s at bits s*W |
| grant_vld_o | output | N | Slot s granted an entry |

## Verification
The bench builds the selector with W = 8, N = 2, AGE_W = 4 and CLS_W = 2, giving two banks of four entries. At that size every one of the 256 ready patterns can be applied in all four mode codes against four age, class and head layouts, so the age windows cross the wrap point, both slots sometimes share a class and compete for the same entries, and each head position lands on ready and idle entries alike. Directed vectors then pin equal-age ties, the wrap comparison, a lone mismatching entry and the one-cycle output delay.

// File: rtl/isel_pkg.sv
package isel_pkg;

    typedef enum logic [1:0] {
        SEL_SHARED = 2'd0,
        SEL_BANKED = 2'd1,
        SEL_QHEAD  = 2'd2,
        SEL_ALIAS  = 2'd3
    } isel_mode_e;

endpackage

// File: rtl/isel_oldest_pick.sv
module isel_oldest_pick #(
    parameter int K     = 8,
    parameter int AGE_W = 4
) (
    input  logic [K-1:0]       cand_i,
    input  logic [K*AGE_W-1:0] age_i,
    output logic [K-1:0]       win_o
);

    function automatic logic precedes(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction

    // An entry wins when no other candidate is older, nor equally old at a lower index.
    always_comb begin
        win_o = '0;
        for (int i = 0; i < K; i++) begin
            win_o[i] = cand_i[i];
            for (int j = 0; j < K; j++) begin
                if (j != i && cand_i[j]) begin
                    if (precedes(age_i[j*AGE_W +: AGE_W], age_i[i*AGE_W +: AGE_W])) begin
                        win_o[i] = 1'b0;
                    end else if (j < i &&
                                 !precedes(age_i[i*AGE_W +: AGE_W], age_i[j*AGE_W +: AGE_W])) begin
                        win_o[i] = 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/isel_class_match.sv
module isel_class_match #(
    parameter int W     = 8,
    parameter int N     = 2,
    parameter int CLS_W = 2
) (
    input  logic [W*CLS_W-1:0]      cls_i,
    input  logic [N*CLS_W-1:0]      slot_cls_i,
    output logic [N-1:0][W-1:0]     match_o
);

    always_comb begin
        match_o = '0;
        for (int s = 0; s < N; s++) begin
            for (int e = 0; e < W; e++) begin
                match_o[s][e] = (cls_i[e*CLS_W +: CLS_W] == slot_cls_i[s*CLS_W +: CLS_W]);
            end
        end
    end

endmodule

// File: rtl/isel_head_decode.sv
module isel_head_decode #(
    parameter int B      = 4,
    parameter int HEAD_W = 2
) (
    input  logic [HEAD_W-1:0] head_i,
    output logic [B-1:0]      onehot_o
);

    always_comb begin
        onehot_o = '0;
        for (int e = 0; e < B; e++) begin
            if (HEAD_W'(e) == head_i) begin
                onehot_o[e] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/age_issue_select.sv
module age_issue_select #(
    parameter int  W      = 8,
    parameter int  N      = 2,
    parameter int  AGE_W  = 4,
    parameter int  CLS_W  = 2,
    localparam int B      = W / N,
    localparam int HEAD_W = (B > 1) ? $clog2(B) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic [W-1:0]          ready_i,
    input  logic [W*AGE_W-1:0]    age_i,
    input  logic [W*CLS_W-1:0]    cls_i,
    input  logic [N*CLS_W-1:0]    slot_cls_i,
    input  logic [N*HEAD_W-1:0]   head_i,
    output logic [N*W-1:0]        grant_o,
    output logic [N-1:0]          grant_vld_o
);

    import isel_pkg::*;

    typedef struct packed {
        logic [N-1:0][W-1:0] grant;
        logic [N-1:0]        vld;
    } isel_state_t;

    isel_state_t st_d, st_q;
    isel_mode_e  mode;

    logic [N-1:0][W-1:0] match;
    logic [W-1:0]        uni_cand [N];
    logic [W-1:0]        uni_win  [N];
    logic [W-1:0]        taken    [N+1];
    logic [B-1:0]        bank_win [N];
    logic [B-1:0]        head_win [N];

    assign mode = isel_mode_e'(mode_i);

    isel_class_match #(.W(W), .N(N), .CLS_W(CLS_W)) u_match (
        .cls_i      (cls_i),
        .slot_cls_i (slot_cls_i),
        .match_o    (match)
    );

    // Shared window: slots chained in ascending order, each masking what lower slots took.
    assign taken[0] = '0;

    for (genvar s = 0; s < N; s++) begin : g_shared
        assign uni_cand[s] = ready_i & match[s] & ~taken[s];

        isel_oldest_pick #(.K(W), .AGE_W(AGE_W)) u_pick (
            .cand_i (uni_cand[s]),
            .age_i  (age_i),
            .win_o  (uni_win[s])
        );

        assign taken[s+1] = taken[s] | uni_win[s];
    end

    // Partitioned and queue-head schemes: one bank of B entries per slot.
    for (genvar s = 0; s < N; s++) begin : g_bank
        logic [B-1:0] bank_cand;
        logic [B-1:0] head_oh;

        assign bank_cand = ready_i[s*B +: B] & match[s][s*B +: B];

        isel_oldest_pick #(.K(B), .AGE_W(AGE_W)) u_pick (
            .cand_i (bank_cand),
            .age_i  (age_i[s*B*AGE_W +: B*AGE_W]),
            .win_o  (bank_win[s])
        );

        isel_head_decode #(.B(B), .HEAD_W(HEAD_W)) u_head (
            .head_i   (head_i[s*HEAD_W +: HEAD_W]),
            .onehot_o (head_oh)
        );

        assign head_win[s] = head_oh & bank_cand;
    end

    always_comb begin
        st_d = '0;
        for (int s = 0; s < N; s++) begin
            case (mode)
                SEL_BANKED: begin
                    for (int e = 0; e < B; e++) begin
                        st_d.grant[s][s*B + e] = bank_win[s][e];
                    end
                end
                SEL_QHEAD: begin
                    for (int e = 0; e < B; e++) begin
                        st_d.grant[s][s*B + e] = head_win[s][e];
                    end
                end
                default: begin
                    st_d.grant[s] = uni_win[s];
                end
            endcase
            st_d.vld[s] = |st_d.grant[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int s = 0; s < N; s++) begin
            grant_o[s*W +: W] = st_q.grant[s];
        end
    end

    assign grant_vld_o = st_q.vld;

endmodule

// File: rtl/isel_checker.sv
module isel_checker #(
    parameter int W      = 8,
    parameter int N      = 2,
    parameter int AGE_W  = 4,
    parameter int CLS_W  = 2,
    parameter int B      = 4,
    parameter int HEAD_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode_i,
    input logic [W-1:0]        ready_i,
    input logic [W*AGE_W-1:0]  age_i,
    input logic [W*CLS_W-1:0]  cls_i,
    input logic [N*CLS_W-1:0]  slot_cls_i,
    input logic [N*HEAD_W-1:0] head_i,
    input logic [N*W-1:0]      grant_o,
    input logic [N-1:0]        grant_vld_o
);

    logic                live_q;
    logic [1:0]          mode_p;
    logic [W-1:0]        ready_p;
    logic [W*AGE_W-1:0]  age_p;
    logic [W*CLS_W-1:0]  cls_p;
    logic [N*CLS_W-1:0]  scls_p;
    logic [N*HEAD_W-1:0] head_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        mode_p  <= mode_i;
        ready_p <= ready_i;
        age_p   <= age_i;
        cls_p   <= cls_i;
        scls_p  <= slot_cls_i;
        head_p  <= head_i;
    end

    function automatic logic precedes(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction

    logic              shared_p;
    logic [N-1:0]      bad_class;
    logic [N-1:0]      bad_bank;
    logic [N-1:0]      bad_head;
    logic              bad_ready;
    logic              overlap;
    logic              older_skipped;
    logic              slot0_has_cand;
    logic [W-1:0]      used;

    assign shared_p = (mode_p == 2'd0) || (mode_p == 2'd3);

    always_comb begin
        bad_class = '0;
        bad_bank  = '0;
        bad_head  = '0;
        bad_ready = 1'b0;
        overlap   = 1'b0;
        used      = '0;
        older_skipped  = 1'b0;
        slot0_has_cand = 1'b0;
        for (int s = 0; s < N; s++) begin
            for (int e = 0; e < W; e++) begin
                if (grant_o[s*W + e]) begin
                    if (cls_p[e*CLS_W +: CLS_W] != scls_p[s*CLS_W +: CLS_W]) bad_class[s] = 1'b1;
                    if (!ready_p[e]) bad_ready = 1'b1;
                    if (used[e]) overlap = 1'b1;
                    if (e < s*B || e >= s*B + B) bad_bank[s] = 1'b1;
                    if (e != s*B + int'(head_p[s*HEAD_W +: HEAD_W])) bad_head[s] = 1'b1;
                    used[e] = 1'b1;
                end
            end
        end
        for (int j = 0; j < W; j++) begin
            if (ready_p[j] && cls_p[j*CLS_W +: CLS_W] == scls_p[0 +: CLS_W]) begin
                slot0_has_cand = 1'b1;
                for (int i = 0; i < W; i++) begin
                    if (grant_o[i] && i != j) begin
                        if (precedes(age_p[j*AGE_W +: AGE_W], age_p[i*AGE_W +: AGE_W])) older_skipped = 1'b1;
                        else if (j < i && !precedes(age_p[i*AGE_W +: AGE_W], age_p[j*AGE_W +: AGE_W]))
                            older_skipped = 1'b1;
                    end
                end
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (grant_o == '0 && grant_vld_o == '0)); // R1

    AST_READY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> !bad_ready); // R4

    AST_CLASS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> bad_class == '0); // R3

    AST_NO_DOUBLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> !overlap); // R7

    AST_SHARED_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && shared_p) |-> !older_skipped); // R5

    AST_SHARED_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && shared_p && slot0_has_cand) |-> grant_vld_o[0]); // R5

    AST_BANK_CONFINE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && mode_p == 2'd1) |-> bad_bank == '0); // R8

    AST_HEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && mode_p == 2'd2) |-> bad_head == '0); // R9

    for (genvar s = 0; s < N; s++) begin : g_slot
        AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_o[s*W +: W]) && (grant_vld_o[s] == |grant_o[s*W +: W])); // R10
    end

endmodule

bind age_issue_select isel_checker #(
    .W(W), .N(N), .AGE_W(AGE_W), .CLS_W(CLS_W), .B(B), .HEAD_W(HEAD_W)
) u_isel_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .ready_i     (ready_i),
    .age_i       (age_i),
    .cls_i       (cls_i),
    .slot_cls_i  (slot_cls_i),
    .head_i      (head_i),
    .grant_o     (grant_o),
    .grant_vld_o (grant_vld_o)
);

// File: tb/age_issue_select_bench.sv
module age_issue_select_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W      = 8;
    localparam int N      = 2;
    localparam int AGE_W  = 4;
    localparam int CLS_W  = 2;
    localparam int B      = W / N;
    localparam int HEAD_W = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          mode_i = '0;
    logic [W-1:0]        ready_i = '0;
    logic [W*AGE_W-1:0]  age_i = '0;
    logic [W*CLS_W-1:0]  cls_i = '0;
    logic [N*CLS_W-1:0]  slot_cls_i = '0;
    logic [N*HEAD_W-1:0] head_i = '0;
    logic [N*W-1:0]      grant_o;
    logic [N-1:0]        grant_vld_o;

    int checks = 0;
    int fails  = 0;

    int age_a  [W];
    int cls_a  [W];
    int scls_a [N];
    int head_a [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    age_issue_select #(.W(W), .N(N), .AGE_W(AGE_W), .CLS_W(CLS_W)) u_age_issue_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .ready_i     (ready_i),
        .age_i       (age_i),
        .cls_i       (cls_i),
        .slot_cls_i  (slot_cls_i),
        .head_i      (head_i),
        .grant_o     (grant_o),
        .grant_vld_o (grant_vld_o)
    );

    function automatic bit is_older(int a, int b);
        return (((a - b) & 15) >= 8);
    endfunction

    function automatic logic [N*W-1:0] model(int m, logic [W-1:0] rdy);
        logic [N*W-1:0] g;
        bit used [W];
        g = '0;
        for (int e = 0; e < W; e++) used[e] = 0;
        for (int s = 0; s < N; s++) begin
            int best;
            best = -1;
            if (m == 2) begin
                int e;
                e = s*B + head_a[s];
                if (rdy[e] && cls_a[e] == scls_a[s]) best = e;
            end else begin
                for (int e = 0; e < W; e++) begin
                    bit ok;
                    ok = rdy[e] && cls_a[e] == scls_a[s] && !used[e];
                    if (m == 1 && (e < s*B || e >= s*B + B)) ok = 0;
                    if (ok && (best < 0 || is_older(age_a[e], age_a[best]))) best = e;
                end
            end
            if (best >= 0) begin
                g[s*W + best] = 1'b1;
                used[best] = 1;
            end
        end
        return g;
    endfunction

    function automatic logic [N-1:0] vld_of(logic [N*W-1:0] g);
        logic [N-1:0] v;
        for (int s = 0; s < N; s++) v[s] = |g[s*W +: W];
        return v;
    endfunction

    task automatic apply(int m, logic [W-1:0] rdy);
        mode_i  = 2'(m);
        ready_i = rdy;
        for (int e = 0; e < W; e++) begin
            age_i[e*AGE_W +: AGE_W] = AGE_W'(age_a[e]);
            cls_i[e*CLS_W +: CLS_W] = CLS_W'(cls_a[e]);
        end
        for (int s = 0; s < N; s++) begin
            slot_cls_i[s*CLS_W +: CLS_W] = CLS_W'(scls_a[s]);
            head_i[s*HEAD_W +: HEAD_W]   = HEAD_W'(head_a[s]);
        end
    endtask

    task automatic check(string req, logic [N*W-1:0] exp_g);
        checks++;
        if (grant_o !== exp_g || grant_vld_o !== vld_of(exp_g)) begin
            fails++;
            $display("FAIL %s: grant=%h vld=%b expected grant=%h vld=%b",
                     req, grant_o, grant_vld_o, exp_g, vld_of(exp_g));
        end
    endtask

    task automatic layout(int p, int r);
        for (int e = 0; e < W; e++) begin
            age_a[e] = (p*5 + ((e*3 + p) % 8)) % 16;
            cls_a[e] = (e + p + (e >> 2)) & 1;
        end
        for (int s = 0; s < N; s++) begin
            scls_a[s] = (p == 3) ? 0 : ((s + p) & 1);
            head_a[s] = (r + s + p) % B;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [N*W-1:0] prev;
        string tag;

        // R1: reset holds grants at zero even with eligible entries
        layout(0, 0);
        @(negedge clk);
        apply(0, 8'hFF);
        @(negedge clk);
        @(negedge clk);
        check("R1 during reset", '0);
        rst_n = 1'b1;
        #1;
        check("R1 after release", '0);
        @(negedge clk);

        // Sweep: every ready pattern, every mode code, four layouts
        for (int m = 0; m < 4; m++) begin
            case (m)
                0: tag = "R5 R7 shared";
                1: tag = "R8 partitioned";
                2: tag = "R9 queue head";
                default: tag = "R11 alias";
            endcase
            for (int p = 0; p < 4; p++) begin
                for (int r = 0; r < 256; r++) begin
                    layout(p, r);
                    apply(m, 8'(r));
                    @(negedge clk);
                    check(tag, model(m, 8'(r)));
                end
            end
        end

        // R6: age 15 is older than age 1 across the wrap
        for (int e = 0; e < W; e++) begin age_a[e] = 2; cls_a[e] = 0; end
        scls_a[0] = 0; scls_a[1] = 1; head_a[0] = 0; head_a[1] = 0;
        age_a[1] = 1; age_a[3] = 15;
        apply(0, 8'b0000_1010);
        @(negedge clk);
        check("R6 wrap", 16'h0008);

        // R5: equal ages resolve to the lowest index
        for (int e = 0; e < W; e++) age_a[e] = 7;
        apply(0, 8'b1010_0100);
        @(negedge clk);
        check("R5 tie", 16'h0004);

        // R3: lone ready entry of a foreign class is not granted
        cls_a[5] = 2;
        apply(0, 8'b0010_0000);
        @(negedge clk);
        check("R3 class mismatch", '0);

        // R2: output holds the previous result until the next edge
        cls_a[5] = 0;
        apply(0, 8'b0010_0000);
        @(negedge clk);
        prev = 16'h0020;
        check("R2 settle", prev);
        apply(0, 8'b0000_0001);
        #1;
        check("R2 before edge", prev);
        @(negedge clk);
        check("R2 after edge", 16'h0001);

        // R7: both slots share a class, second slot takes the next oldest
        scls_a[1] = 0;
        for (int e = 0; e < W; e++) age_a[e] = 9 - e;
        apply(0, 8'b1001_0010);
        @(negedge clk);
        check("R7 mask", {8'b0001_0000, 8'b1000_0000});

        finish_run();
    end

endmodule